// File: doc/BRIEF.md
# Programmable power-on reset sequencer

This block keeps a configuration controller, and the logic attached to it, in reset after power comes up or after a fault. It waits for an external supply-good comparator to report a stable supply. It then runs a delay counter whose length is chosen by a pin, and at the end it lets go of a shared open-drain enable line. The enable line is wired-AND. Another device may keep it low to stretch the reset, so the block takes the level it senses on the line as the true end of reset.

Once released, the block watches for three conditions that send it back into reset: the supply-good flag dropping, the downstream device pulling its status line low, and a configuration failure, which is configuration-done still low when the engine strobes that all data has been sent. Until reset is fully complete, a gate output refuses test-port and in-system-programming commands.

Every asynchronous input passes through a two-flop synchronizer. The two delays come from a clock-frequency parameter: 2 ms when the select pin is high and 100 ms when it is low.

Top module: `pwr_reset_seq`

## Requirements
- R1: While the chip reset `rstN` is low, and afterwards while the supply is not good, `enOe` is 1, `porDone` is 0 and `cmdBlock` is 1.
- R2: While `supplyGood` stays low the delay counter never starts, and `enOe` stays 1 however long this lasts.
- R3: With `fastSel` high, `enOe` falls exactly SHORT_MS*CLK_HZ/1000 + 3 clock cycles after `supplyGood` rises. The 3 extra cycles are two synchronizer stages and one load cycle.
- R4: With `fastSel` low, `enOe` falls exactly LONG_MS*CLK_HZ/1000 + 3 clock cycles after `supplyGood` rises.
- R5: `fastSel` is sampled only when a count starts. Changing it during a count does not alter that count's length.
- R6: `porDone` is 1 only when the block has released the line and the synchronized `enSense` reads high. It rises 2 cycles after an external holder lets go of the line.
- R7: If `supplyGood` falls at any time after it was good, `enOe` returns to 1 three cycles after the fall, and a new full count is needed once the supply returns.
- R8: A low on `devStatusN` while released drives `enOe` to 1 three cycles later. The block then holds one error-reset cycle and a full count, so the line is released again N+4 cycles after the low began.
- R9: An `allSent` pulse while released and synchronized `cfgDone` is low drives `enOe` to 1 on the next cycle, and after one error-reset cycle and a full count the line is released N+2 cycles after the pulse. With `cfgDone` high, `allSent` has no effect.
- R10: `cmdBlock` is always the inverse of `porDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low chip reset |
| supplyGood | input | 1 | Supply-good flag from the external comparator, asynchronous |
| fastSel | input | 1 | Delay select: 1 gives the short delay, 0 the long one, asynchronous |
| devStatusN | input | 1 | Downstream status line, low requests reconfiguration, asynchronous |
| cfgDone | input | 1 | Downstream configuration-done line, asynchronous |
| allSent | input | 1 | One-cycle strobe from the configuration engine: all data has been sent |
| enSense | input | 1 | Sensed level of the shared enable line |
| enOe | output | 1 | 1 drives the shared enable line low, 0 releases it |
| porDone | output | 1 | Reset sequence complete |
| cmdBlock | output | 1 | 1 refuses test-port and in-system-programming commands |

## Verification
The asynchronous inputs each pass through two synchronizer flops, so an enable change caused by the supply or status line is due on the third rising edge after the input changes. Release after a count is due at N+3 edges, or N+4 when the count follows an error-reset cycle. The synchronous `allSent` strobe acts on the very next edge. `porDone` trails the sensed line by two edges. The bench drives inputs on falling edges and counts falling edges from each stimulus. It compares the exact count at which `enOe` changes with these figures and checks that the output has not changed one cycle earlier.

// File: rtl/pwr_reset_pkg.sv
package pwr_reset_pkg;

  typedef enum logic [1:0] {
    ST_SUPPLY_WAIT = 2'd0,
    ST_COUNTING    = 2'd1,
    ST_RELEASED    = 2'd2,
    ST_ERROR_RESET = 2'd3
  } porState_e;

  // strobes from control to the delay datapath
  typedef struct packed {
    logic load;
    logic dec;
  } cntCtl_t;

endpackage

// File: rtl/pwr_reset_sync.sv
module pwr_reset_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= din[i];
        stage2 <= stage1;
      end
    end
    assign dout[i] = stage2;
  end

endmodule

// File: rtl/pwr_reset_dp.sv
module pwr_reset_dp
  import pwr_reset_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned LONG_MS  = 100,
  parameter int unsigned SHORT_MS = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCtl_t ctl,
  input  logic    fastSelS,
  output logic    expired
);

  localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
  localparam int unsigned LONG_CYC   = CYC_PER_MS * LONG_MS;
  localparam int unsigned SHORT_CYC  = CYC_PER_MS * SHORT_MS;
  localparam int unsigned CW         = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt;

  // the select is consumed only at load, so it is frozen for the whole count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= fastSelS ? SHORT_LD : LONG_LD;
    end else if (ctl.dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/pwr_reset_ctrl.sv
module pwr_reset_ctrl
  import pwr_reset_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyS,
  input  logic      statusNS,
  input  logic      cfgDoneS,
  input  logic      allSent,
  input  logic      senseS,
  input  logic      expired,
  output cntCtl_t   ctl,
  output porState_e state,
  output logic      enOe,
  output logic      porDone,
  output logic      cmdBlock
);

  porState_e stateNxt;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_SUPPLY_WAIT: begin
        if (supplyS) begin
          stateNxt = ST_COUNTING;
          ctl.load = 1'b1;
        end
      end
      ST_COUNTING: begin
        if (!supplyS)     stateNxt = ST_SUPPLY_WAIT;
        else if (expired) stateNxt = ST_RELEASED;
        else              ctl.dec  = 1'b1;
      end
      ST_RELEASED: begin
        if (!supplyS)                              stateNxt = ST_SUPPLY_WAIT;
        else if (!statusNS || (allSent && !cfgDoneS)) stateNxt = ST_ERROR_RESET;
      end
      ST_ERROR_RESET: begin
        if (!supplyS) begin
          stateNxt = ST_SUPPLY_WAIT;
        end else begin
          stateNxt = ST_COUNTING;
          ctl.load = 1'b1;
        end
      end
      default: stateNxt = ST_SUPPLY_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SUPPLY_WAIT;
    else       state <= stateNxt;
  end

  assign enOe     = (state != ST_RELEASED);
  assign porDone  = (state == ST_RELEASED) && senseS;
  assign cmdBlock = !porDone;

endmodule

// File: rtl/pwr_reset_seq.sv
module pwr_reset_seq
  import pwr_reset_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned LONG_MS  = 100,
  parameter int unsigned SHORT_MS = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGood,
  input  logic fastSel,
  input  logic devStatusN,
  input  logic cfgDone,
  input  logic allSent,
  input  logic enSense,
  output logic enOe,
  output logic porDone,
  output logic cmdBlock
);

  localparam int unsigned NSYNC = 5;
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b00100;

  logic [NSYNC-1:0] rawIn;
  logic [NSYNC-1:0] syncOut;
  logic supplyS, fastSelS, statusNS, cfgDoneS, senseS;
  logic expired;
  cntCtl_t   ctl;
  porState_e state;

  assign rawIn = {supplyGood, fastSel, devStatusN, cfgDone, enSense};
  assign {supplyS, fastSelS, statusNS, cfgDoneS, senseS} = syncOut;

  pwr_reset_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) i_sync (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncOut)
  );

  pwr_reset_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .supplyS(supplyS), .statusNS(statusNS),
    .cfgDoneS(cfgDoneS), .allSent(allSent), .senseS(senseS),
    .expired(expired), .ctl(ctl), .state(state), .enOe(enOe),
    .porDone(porDone), .cmdBlock(cmdBlock)
  );

  pwr_reset_dp #(.CLK_HZ(CLK_HZ), .LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fastSelS(fastSelS), .expired(expired)
  );

endmodule

// File: rtl/pwr_reset_seq_chk.sv
module pwr_reset_seq_chk
  import pwr_reset_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      enOe,
  input logic      porDone,
  input logic      cmdBlock,
  input logic      supplyS,
  input porState_e state
);

  a_r10_gate_inverse: assert property (@(posedge clk) disable iff (!rstN)
    cmdBlock == !porDone);

  a_r6_done_needs_release: assert property (@(posedge clk) disable iff (!rstN)
    porDone |-> !enOe);

  a_r7_supply_loss: assert property (@(posedge clk) disable iff (!rstN)
    (!enOe && !supplyS) |=> enOe);

  a_r2_hold_without_supply: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUPPLY_WAIT && !supplyS) |=> (state == ST_SUPPLY_WAIT));

  // R8 / R9: the error-reset state lasts one cycle, then a fresh count
  a_r8_error_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERROR_RESET && supplyS) |=> (state == ST_COUNTING));

endmodule

bind pwr_reset_seq pwr_reset_seq_chk i_chk (
  .clk(clk), .rstN(rstN), .enOe(enOe), .porDone(porDone),
  .cmdBlock(cmdBlock), .supplyS(supplyS), .state(state)
);

// File: tb/test_pwr_reset_seq.sv
module test_pwr_reset_seq;

  localparam time CLK_PERIOD = 10ns;
  localparam int  CLK_HZ     = 10_000;
  localparam int  NSHORT     = CLK_HZ / 1000 * 2;
  localparam int  NLONG      = CLK_HZ / 1000 * 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b0, fastSel = 1'b1, devStatusN = 1'b1;
  logic cfgDone = 1'b0, allSent = 1'b0, extHold = 1'b0;
  logic enSense, enOe, porDone, cmdBlock;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // wired-AND line with pull-up
  assign enSense = !enOe && !extHold;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_reset_seq #(.CLK_HZ(CLK_HZ)) i_pwr_reset_seq (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .fastSel(fastSel),
    .devStatusN(devStatusN), .cfgDone(cfgDone), .allSent(allSent),
    .enSense(enSense), .enOe(enOe), .porDone(porDone), .cmdBlock(cmdBlock)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  // counts falling edges until the line is released, up to a limit
  task automatic countToRelease(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (enOe && n < 5000);
  endtask

  task automatic dropSupply();
    supplyGood = 1'b0;
    waitNeg(4);
  endtask

  task automatic tResetState();
    waitNeg(3);
    chk("R1 enOe in reset", enOe, 1);
    chk("R1 porDone in reset", porDone, 0);
    rstN = 1'b1;
    waitNeg(3);
    chk("R1 cmdBlock after reset", cmdBlock, 1);
  endtask

  task automatic tSupplyWait();
    waitNeg(200);
    chk("R2 enOe held without supply", enOe, 1);
    chk("R2 porDone held low", porDone, 0);
  endtask

  task automatic tFast();
    int n;
    fastSel = 1'b1;
    supplyGood = 1'b1;
    countToRelease(n);
    chk("R3 short delay cycles", n, NSHORT + 3);
    waitNeg(1);
    chk("R6 porDone one cycle after release", porDone, 0);
    waitNeg(1);
    chk("R6 porDone two cycles after release", porDone, 1);
    chk("R10 cmdBlock lifted", cmdBlock, 0);
  endtask

  task automatic tSupplyLoss();
    int n;
    supplyGood = 1'b0;
    waitNeg(2);
    chk("R7 enOe not yet back", enOe, 0);
    waitNeg(1);
    chk("R7 enOe back after supply loss", enOe, 1);
    chk("R10 cmdBlock back", cmdBlock, 1);
    waitNeg(2);
    supplyGood = 1'b1;
    countToRelease(n);
    chk("R7 full recount after supply returns", n, NSHORT + 3);
  endtask

  task automatic tSlow();
    int n;
    dropSupply();
    fastSel = 1'b0;
    supplyGood = 1'b1;
    countToRelease(n);
    chk("R4 long delay cycles", n, NLONG + 3);
  endtask

  task automatic tSelLatched();
    int n = 0;
    dropSupply();
    fastSel = 1'b0;
    supplyGood = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (n == 100) fastSel = 1'b1;
    end while (enOe && n < 5000);
    chk("R5 select change mid-count ignored", n, NLONG + 3);
  endtask

  task automatic tExtHold();
    int n;
    dropSupply();
    fastSel = 1'b1;
    extHold = 1'b1;
    supplyGood = 1'b1;
    countToRelease(n);
    chk("R6 release under hold", n, NSHORT + 3);
    waitNeg(10);
    chk("R6 porDone low while held", porDone, 0);
    chk("R10 cmdBlock high while held", cmdBlock, 1);
    extHold = 1'b0;
    waitNeg(1);
    chk("R6 porDone one cycle after hold ends", porDone, 0);
    waitNeg(1);
    chk("R6 porDone two cycles after hold ends", porDone, 1);
  endtask

  task automatic tStatusReq();
    int n = 0;
    devStatusN = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) chk("R8 enOe before status acts", enOe, 0);
      if (n == 3) begin
        chk("R8 enOe driven on status request", enOe, 1);
        devStatusN = 1'b1;
      end
    end while ((n <= 3 || enOe) && n < 5000);
    chk("R8 release after status request", n, NSHORT + 4);
  endtask

  task automatic tCfgError();
    int n = 0;
    waitNeg(4);
    cfgDone = 1'b0;
    waitNeg(3);
    allSent = 1'b1;
    do begin
      @(negedge clk);
      allSent = 1'b0;
      n++;
      if (n == 1) chk("R9 enOe on configuration error", enOe, 1);
    end while ((n <= 1 || enOe) && n < 5000);
    chk("R9 release after configuration error", n, NSHORT + 2);
  endtask

  task automatic tCfgOk();
    int seen = 0;
    waitNeg(4);
    cfgDone = 1'b1;
    waitNeg(3);
    allSent = 1'b1;
    @(negedge clk);
    allSent = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (enOe) seen++;
      @(negedge clk);
    end
    chk("R9 allSent ignored with cfgDone high", seen, 0);
    chk("R10 cmdBlock low when done", cmdBlock, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    tResetState();
    tSupplyWait();
    tFast();
    tSupplyLoss();
    tSlow();
    tSelLatched();
    tExtHold();
    tStatusReq();
    tCfgError();
    tCfgOk();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule